// File: doc/BRIEF.md
# Operand Stack Cache with Background Spill and Fill

This block is the operand store of a stack-oriented execution core. It keeps the topmost words of the operand stack in a 64-entry circular buffer of 32-bit words. The execute pipeline pushes, pops and reads the top word directly. The deeper part of the stack lives in data memory, and the two parts together always form one coherent last-in, first-out stack.

A background mover keeps the number of words held on chip between two programmable watermarks. When the buffer holds more words than the upper mark, the mover writes the oldest word out to memory. When it holds fewer than the lower mark and memory still holds words, the mover reads the most recently spilled word back in beneath the oldest entry. Each transfer moves one word through a request/acknowledge port.

The pipeline issues no spill or fill operations of its own. It sees a stall only when a push meets a completely full buffer or a pop meets an empty one. The stall holds until the mover frees a slot or supplies a word.

Top module: `stack_cache`

## Requirements
- R1: After reset the occupancy is 0, `stall` is low, `memReq` is low, and the upper and lower watermarks are 48 and 16.
- R2: Accepted pushes and pops follow last-in, first-out order across all 64 slots, including words that went out to memory and came back. `topData` shows the most recently pushed word that is still on the stack, and the occupancy never exceeds 64.
- R3: A push and a pop accepted in the same cycle replace the top word. The occupancy is unchanged, and the popped value is the old top.
- R4: A pop with occupancy 0 raises `stall` and changes neither the occupancy nor the stack contents. A pop or a replace also stalls when it would take the last word while that word is being spilled.
- R5: A push without a pop when the occupancy is 64 raises `stall` and holds it until the mover has freed a slot. The push is then accepted with its data intact.
- R6: While the occupancy is above the upper watermark and no fill is in progress, the mover writes the oldest word (`memWrite`=1) to word address P and then increments P. In the absence of pipeline traffic the occupancy settles at the upper watermark.
- R7: While the occupancy is below the lower watermark and P is nonzero, the mover reads word address P-1 (`memWrite`=0). It inserts the word beneath the oldest entry and decrements P. No fill is requested when P is 0. The occupancy settles at the lower watermark or at the total stack size, whichever is smaller.
- R8: At most one transfer is in progress at a time, and a fill is chosen over a spill. `memReq`, `memWrite` and `memAddr` hold steady until `memAck`. `memReq` drops in the cycle after `memAck`.
- R9: A cycle with `cfgWe`=1 loads `cfgHigh` and `cfgLow` as the new upper and lower watermarks, and the mover acts on them from the next cycle.
- R10: A push never completes when the occupancy is 63 while a fill is in progress, and a spill never removes a word that a pop takes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request from the pipeline |
| pushData | input | 32 | Word to push |
| popReq | input | 1 | Pop request from the pipeline |
| topData | output | 32 | Current top-of-stack word (valid when occupancy is nonzero) |
| occupancy | output | 7 | Number of words held on chip |
| stall | output | 1 | Pipeline request cannot be accepted this cycle |
| cfgWe | input | 1 | Watermark write strobe |
| cfgHigh | input | 7 | New upper watermark |
| cfgLow | input | 7 | New lower watermark |
| memReq | output | 1 | Memory transfer request |
| memWrite | output | 1 | 1 for spill (write), 0 for fill (read) |
| memAddr | output | 16 | Word address in the memory-resident stack |
| memWData | output | 32 | Word being spilled |
| memRData | input | 32 | Word returned for a fill, valid with memAck |
| memAck | input | 1 | Completes the current transfer |

## Verification
The pipeline and the mover both change the occupancy and the buffer pointers, so a pop can coincide with a spill acknowledge and a push can coincide with a fill acknowledge. The first collision is provoked by setting the upper mark to 0 and the lower mark to 1, which keeps the mover spilling and filling the single remaining word while pushes and pops are held against it. The second is provoked by draining a deep stack while fills run and then refilling it. The result is judged by a scoreboard that compares every popped word with an independent last-in, first-out model, together with occupancy and memory-traffic counts checked after the mover has settled.

// File: rtl/stkc_pkg.sv
package stkc_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;       // write pushData above the top (or over it with pop)
    logic pop;        // remove the top word
    logic spillDone;  // oldest word has been written to memory
    logic fillDone;   // memRData goes beneath the oldest word
    logic fillSel;    // memory address refers to a fill read
  } stkCtl_t;

endpackage

// File: rtl/stkc_datapath.sv
module stkc_datapath
  import stkc_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int WIDTH   = 32,
  parameter int MADDR_W = 16,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int CNT_W   = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  stkCtl_t            ctl,
  input  logic [WIDTH-1:0]   pushData,
  input  logic [WIDTH-1:0]   memRData,
  output logic [WIDTH-1:0]   topData,
  output logic [CNT_W-1:0]   count,
  output logic [MADDR_W-1:0] memSp,
  output logic [MADDR_W-1:0] memAddr,
  output logic [WIDTH-1:0]   memWData
);

  localparam logic [PTR_W-1:0]   PTR_ONE = PTR_W'(1);
  localparam logic [CNT_W-1:0]   CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0]   CNT_MAX = CNT_W'(DEPTH);
  localparam logic [MADDR_W-1:0] SP_ONE  = MADDR_W'(1);

  logic [WIDTH-1:0]   store [DEPTH];
  logic [PTR_W-1:0]   botPtr;
  logic [PTR_W-1:0]   topIdx;
  logic [PTR_W-1:0]   pushIdx;
  logic [PTR_W-1:0]   fillIdx;
  logic [PTR_W-1:0]   botNext;
  logic [CNT_W-1:0]   cntNext;
  logic [MADDR_W-1:0] spNext;

  // Slot positions relative to the oldest entry; all wrap modulo DEPTH
  assign topIdx  = botPtr + count[PTR_W-1:0] - PTR_ONE;
  assign pushIdx = ctl.pop ? topIdx : botPtr + count[PTR_W-1:0];
  assign fillIdx = botPtr - PTR_ONE;

  assign topData  = store[topIdx];
  assign memWData = store[botPtr];
  assign memAddr  = ctl.fillSel ? memSp - SP_ONE : memSp;

  always_comb begin
    cntNext = count;
    if (ctl.push)      cntNext = cntNext + CNT_ONE;
    if (ctl.pop)       cntNext = cntNext - CNT_ONE;
    if (ctl.spillDone) cntNext = cntNext - CNT_ONE;
    if (ctl.fillDone)  cntNext = cntNext + CNT_ONE;
  end

  always_comb begin
    botNext = botPtr;
    spNext  = memSp;
    if (ctl.spillDone) begin
      botNext = botPtr + PTR_ONE;
      spNext  = memSp + SP_ONE;
    end else if (ctl.fillDone) begin
      botNext = fillIdx;
      spNext  = memSp - SP_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      botPtr <= '0;
      count  <= '0;
      memSp  <= '0;
    end else begin
      botPtr <= botNext;
      count  <= cntNext;
      memSp  <= spNext;
    end
  end

  // Two write ports: the pipeline at the top, the mover below the bottom
  always_ff @(posedge clk) begin
    if (ctl.push)     store[pushIdx] <= pushData;
    if (ctl.fillDone) store[fillIdx] <= memRData;
  end

  AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_MAX);  // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> count != '0);  // R4
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !ctl.pop) |-> count < CNT_MAX);  // R5
  AST_FILL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillDone |-> memSp != '0);  // R7
  AST_SPILL_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.spillDone && ctl.pop) |-> count > CNT_ONE);  // R10
  AST_FILL_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fillDone && ctl.push && !ctl.pop) |-> count < CNT_MAX - CNT_ONE);  // R10
  AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.spillDone && ctl.fillDone));  // R8

endmodule

// File: rtl/stkc_control.sv
module stkc_control
  import stkc_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int CNT_W   = 7,
  parameter int MADDR_W = 16,
  parameter int HI_RST  = 48,
  parameter int LO_RST  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic               popReq,
  input  logic               cfgWe,
  input  logic [CNT_W-1:0]   cfgHigh,
  input  logic [CNT_W-1:0]   cfgLow,
  input  logic [CNT_W-1:0]   count,
  input  logic [MADDR_W-1:0] memSp,
  input  logic               memAck,
  output stkCtl_t            ctl,
  output logic               stall,
  output logic               memReq,
  output logic               memWrite
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_NEAR = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [1:0] { DR_IDLE, DR_SPILL, DR_FILL } drState_t;

  drState_t         state, stateNext;
  logic [CNT_W-1:0] hiMark, loMark;
  logic             spillBusy, fillBusy;
  logic             popBlocked, pushBlocked;
  logic             doPush, doPop;
  logic             wantFill, wantSpill;

  assign spillBusy = (state == DR_SPILL);
  assign fillBusy  = (state == DR_FILL);

  // Pop may not take a word the mover is currently writing out
  assign popBlocked  = (count == '0) || (spillBusy && count == CNT_ONE);
  // Plain push may not take the slot a pending fill is about to use
  assign pushBlocked = (count == CNT_MAX) || (fillBusy && count == CNT_NEAR);

  assign stall  = popReq ? popBlocked : (pushValid && pushBlocked);
  assign doPop  = popReq && !stall;
  assign doPush = pushValid && !stall;

  // Start decisions look at this cycle's pipeline action as well
  assign wantFill  = (count < loMark) && (count < CNT_NEAR) && (memSp != '0)
                     && !(count == CNT_NEAR - CNT_ONE && doPush && !doPop);
  assign wantSpill = (count > hiMark) && !(count == CNT_ONE && doPop);

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    ctl.push      = doPush;
    ctl.pop       = doPop;
    ctl.fillSel   = fillBusy;
    unique case (state)
      DR_IDLE: begin
        if (wantFill)       stateNext = DR_FILL;
        else if (wantSpill) stateNext = DR_SPILL;
      end
      DR_SPILL: begin
        if (memAck) begin
          ctl.spillDone = 1'b1;
          stateNext     = DR_IDLE;
        end
      end
      DR_FILL: begin
        if (memAck) begin
          ctl.fillDone = 1'b1;
          stateNext    = DR_IDLE;
        end
      end
      default: stateNext = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= DR_IDLE;
      hiMark <= CNT_W'(HI_RST);
      loMark <= CNT_W'(LO_RST);
    end else begin
      state <= stateNext;
      if (cfgWe) begin
        hiMark <= cfgHigh;
        loMark <= cfgLow;
      end
    end
  end

  assign memReq   = spillBusy || fillBusy;
  assign memWrite = spillBusy;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWrite)));  // R8
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !memReq);  // R8
  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (stall && popReq) |-> !ctl.pop);  // R4
  AST_STRIDE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillDone |-> memSp != '0);  // R7

endmodule

// File: rtl/stack_cache.sv
module stack_cache
  import stkc_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int WIDTH   = 32,
  parameter int MADDR_W = 16,
  parameter int HI_RST  = 48,
  parameter int LO_RST  = 16,
  parameter int CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic [WIDTH-1:0]   pushData,
  input  logic               popReq,
  output logic [WIDTH-1:0]   topData,
  output logic [CNT_W-1:0]   occupancy,
  output logic               stall,
  input  logic               cfgWe,
  input  logic [CNT_W-1:0]   cfgHigh,
  input  logic [CNT_W-1:0]   cfgLow,
  output logic               memReq,
  output logic               memWrite,
  output logic [MADDR_W-1:0] memAddr,
  output logic [WIDTH-1:0]   memWData,
  input  logic [WIDTH-1:0]   memRData,
  input  logic               memAck
);

  localparam int PTR_W = $clog2(DEPTH);

  stkCtl_t            ctl;
  logic [CNT_W-1:0]   count;
  logic [MADDR_W-1:0] memSp;

  stkc_control #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .MADDR_W(MADDR_W),
    .HI_RST(HI_RST), .LO_RST(LO_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .popReq(popReq),
    .cfgWe(cfgWe), .cfgHigh(cfgHigh), .cfgLow(cfgLow),
    .count(count), .memSp(memSp), .memAck(memAck),
    .ctl(ctl), .stall(stall), .memReq(memReq), .memWrite(memWrite)
  );

  stkc_datapath #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .MADDR_W(MADDR_W),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .pushData(pushData), .memRData(memRData),
    .topData(topData), .count(count), .memSp(memSp),
    .memAddr(memAddr), .memWData(memWData)
  );

  assign occupancy = count;

endmodule

// File: tb/stack_cache_tb.sv
module stack_cache_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0;
  logic [31:0] pushData = '0;
  logic        popReq = 1'b0;
  logic [31:0] topData;
  logic [6:0]  occupancy;
  logic        stall;
  logic        cfgWe = 1'b0;
  logic [6:0]  cfgHigh = '0;
  logic [6:0]  cfgLow = '0;
  logic        memReq, memWrite;
  logic [15:0] memAddr;
  logic [31:0] memWData;
  logic [31:0] memRData = '0;
  logic        memAck = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int memWrites = 0;
  int memReads = 0;
  bit finished = 0;

  logic [31:0] refStack [$];
  logic [31:0] expQ [$];
  logic [31:0] memArr [256];
  int          ackDly = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_cache u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .topData(topData), .occupancy(occupancy), .stall(stall),
    .cfgWe(cfgWe), .cfgHigh(cfgHigh), .cfgLow(cfgLow),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .memAck(memAck)
  );

  // Memory model: acknowledges two cycles into a request
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      if (ackDly == 1) begin
        memAck <= 1'b1;
        ackDly <= 0;
        if (memWrite) begin
          memArr[memAddr[7:0]] <= memWData;
          memWrites <= memWrites + 1;
        end else begin
          memRData <= memArr[memAddr[7:0]];
          memReads <= memReads + 1;
        end
      end else begin
        ackDly <= ackDly + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every accepted pop is compared with the scoreboard (R2, R3)
  always @(negedge clk) begin
    if (rstN && popReq && !stall) begin
      if (expQ.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R2: pop accepted with nothing expected, actual 0x%0h expected none", topData);
      end else begin
        chk("R2 pop order", topData, expQ.pop_front());
      end
    end
  end

  task automatic waitAccept();
    bit acc;
    do begin
      @(negedge clk);
      acc = !stall;
      @(posedge clk);
      #1;
    end while (!acc);
  endtask

  task automatic pushItem(input logic [31:0] v);
    pushValid = 1'b1;
    pushData  = v;
    refStack.push_back(v);
    waitAccept();
    pushValid = 1'b0;
  endtask

  task automatic popItem();
    popReq = 1'b1;
    expQ.push_back(refStack.pop_back());
    waitAccept();
    popReq = 1'b0;
  endtask

  task automatic setMarks(input logic [6:0] hi, input logic [6:0] lo);
    cfgWe = 1'b1; cfgHigh = hi; cfgLow = lo;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 occupancy", 32'(occupancy), 0);
    chk("R1 stall", 32'(stall), 0);
    chk("R1 memReq", 32'(memReq), 0);
    @(posedge clk); #1;

    // R6, R1 (upper mark 48): spill settles at the mark
    for (int i = 0; i < 60; i++) pushItem(32'h1000 + 32'(i));
    idle(300);
    @(negedge clk);
    chk("R6 occupancy at upper mark", 32'(occupancy), 48);
    chk("R6 words spilled", 32'(memWrites), 12);
    chk("R2 top word", topData, 32'h1000 + 59);
    @(posedge clk); #1;

    // R7, R1 (lower mark 16): fill settles at the mark
    for (int i = 0; i < 40; i++) popItem();
    idle(300);
    @(negedge clk);
    chk("R7 occupancy at lower mark", 32'(occupancy), 16);
    chk("R7 words filled", 32'(memReads), 8);
    @(posedge clk); #1;

    // R7: drain completely, no fill once memory is empty
    for (int i = 0; i < 20; i++) popItem();
    idle(50);
    @(negedge clk);
    chk("R7 drained occupancy", 32'(occupancy), 0);
    chk("R7 no request with empty memory", 32'(memReq), 0);
    chk("R7 total fills", 32'(memReads), 12);
    @(posedge clk); #1;

    // R4: pop on empty stalls and changes nothing
    popReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 stall on empty pop", 32'(stall), 1);
      chk("R4 occupancy unchanged", 32'(occupancy), 0);
      @(posedge clk); #1;
    end
    popReq = 1'b0;

    // R3: simultaneous push and pop replace the top
    pushItem(32'hA);
    pushValid = 1'b1; pushData = 32'hB; popReq = 1'b1;
    expQ.push_back(refStack.pop_back());
    refStack.push_back(32'hB);
    waitAccept();
    pushValid = 1'b0; popReq = 1'b0;
    @(negedge clk);
    chk("R3 top replaced", topData, 32'hB);
    chk("R3 occupancy kept", 32'(occupancy), 1);
    @(posedge clk); #1;

    // R9, R5: marks that disable spilling, then full-buffer stall
    setMarks(7'd64, 7'd0);
    for (int i = 0; i < 63; i++) pushItem(32'h2000 + 32'(i));
    pushValid = 1'b1; pushData = 32'h3000;
    refStack.push_back(32'h3000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 stall when full", 32'(stall), 1);
      chk("R5 full occupancy", 32'(occupancy), 64);
      @(posedge clk); #1;
    end
    chk("R9 no spill above programmed mark", 32'(memWrites), 12);
    setMarks(7'd40, 7'd16);
    waitAccept();
    pushValid = 1'b0;
    idle(400);
    @(negedge clk);
    chk("R9 occupancy at new upper mark", 32'(occupancy), 40);
    chk("R6 cumulative spills", 32'(memWrites), 37);
    chk("R5 held push landed on top", topData, 32'h3000);
    @(posedge clk); #1;
    for (int i = 0; i < 65; i++) popItem();
    idle(100);
    @(negedge clk);
    chk("R7 all words returned", 32'(memReads), 37);
    chk("R2 empty after drain", 32'(occupancy), 0);
    @(posedge clk); #1;

    // R10, R8: mover toggling on the last word while the pipeline works
    setMarks(7'd0, 7'd1);
    for (int i = 0; i < 6; i++) pushItem(32'h4000 + 32'(i));
    for (int i = 0; i < 6; i++) popItem();
    idle(60);
    @(negedge clk);
    chk("R10 occupancy after tight drain", 32'(occupancy), 0);
    chk("R8 mover idle", 32'(memReq), 0);
    chk("R10 scoreboard empty", 32'(expQ.size()), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule